// File: doc/BRIEF.md
# Accumulator Group Row Sequencer

This block produces the order in which accumulator-array rows are visited by a widening multiply-subtract that reads one, two or four source vector registers. A start pulse supplies the request. The request holds a 2-bit base-register select, the 32-bit value of that base register, a 2-bit offset field, a group-count code and the first source register. The block then emits one step per cycle. Each step carries a row index, the source register in use and a sub-lane index. The array holds `VEC_BITS/8` rows. The group is laid out with a stride equal to the row count divided by the group count.

The sequencer uses four states. It waits in `IDLE`. A legal start moves it to `RUN` (transition *accept*). It stays in `RUN` for 4×G steps and then moves to `FIN` (transition *last_step*). From `FIN` it returns to `IDLE` on the next cycle (transition *retire*). A start that asks for 64-bit accumulators while the wide-input feature is absent, or that carries the reserved group code, goes from `IDLE` to `FAULT` (transition *reject*). From `FAULT` it returns to `IDLE` on the next cycle (transition *clear*).

Top module: `acc_row_seq`

## Requirements
- R1: After reset `valid_o`, `done_o` and `fault_o` are 0.
- R2: While `valid_o` is 1, `base_reg_o` equals 8 + `base_sel_i`, taken from the accepted start.
- R3: Group code 0, 1 and 2 select G = 1, 2 and 4. Stride S = (VEC_BITS/8)/G. The start row is (base value + 4×offset field) mod S, with the base value treated as unsigned 32-bit. That result is then rounded down to a multiple of 4.
- R4: For each source register, four consecutive steps carry `sub_o` = 0,1,2,3 and `row_o` = current row + `sub_o`.
- R5: Source register r (0 ≤ r < G) is (`first_reg_i` + r) mod 32, and its current row is start row + r×S.
- R6: `valid_o` is 1 for exactly 4×G consecutive cycles. The first of these is the cycle after the edge that accepts the start. `done_o` is 1 for the single cycle that follows the last step.
- R7: A start that arrives while the block is in `RUN` or `FIN` is ignored and does not change the sequence in progress.
- R8: A start with size code 1 and `wide_ok_i` = 0, or with group code 3, produces no steps. `fault_o` is 1 for one cycle, in the cycle after the edge that accepts the start.
- R9: Base values near 2^32 wrap mod 2^32 before the stride modulo, and the start row stays within the stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse |
| base_sel_i | input | 2 | Base-register select |
| base_val_i | input | 32 | Value of the selected base register |
| offs_i | input | 2 | Offset field (row offset = 4 × field) |
| grp_i | input | 2 | Group code: 0→1, 1→2, 2→4 registers, 3 reserved |
| first_reg_i | input | 5 | First source register |
| size_i | input | 1 | 0: 32-bit accumulators, 1: 64-bit accumulators |
| wide_ok_i | input | 1 | 16-bit-input feature present |
| valid_o | output | 1 | Step valid |
| row_o | output | ROW_W | Accumulator row of the step |
| src_reg_o | output | 5 | Source register of the step |
| sub_o | output | 2 | Sub-lane index 0..3 |
| base_reg_o | output | 4 | Number of the base register in use |
| done_o | output | 1 | One-cycle pulse after the last step |
| fault_o | output | 1 | One-cycle pulse for a rejected start |

## Verification
Random requests vary the base value over the full 32-bit range and mix all three group sizes, offsets and first registers. This shows whether the stride modulo and the round-down to a multiple of 4 are right for each group size. Directed cases cover a first register of 30 or 31, which tests the wrap of the register index past 31. They also cover base values just below 2^32, which tests the 32-bit wrap ahead of the modulo. Further cases send starts during `RUN` and `FIN` to show they are ignored, and send both kinds of illegal request to show they are rejected.

// File: rtl/acc_row_pkg.sv
package acc_row_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FIN   = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_t;

    localparam logic [1:0] GRP_RESERVED = 2'd3;
    localparam int         REG_COUNT    = 32;
    localparam int         REG_W        = $clog2(REG_COUNT);
endpackage

// File: rtl/acc_row_origin.sv
module acc_row_origin #(
    parameter int ROWS  = 64,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic [31:0]      base_val,
    input  logic [1:0]       offs,
    input  logic [1:0]       grp,
    output logic [ROW_W:0]   stride,
    output logic [ROW_W-1:0] row0
);
    logic [31:0]      sum_w;
    logic [ROW_W-1:0] mask_w;

    always_comb begin
        stride = (ROW_W+1)'(ROWS) >> grp;
        mask_w = ROW_W'(stride - 1'b1);
        sum_w  = base_val + {28'd0, offs, 2'b00};
        row0   = sum_w[ROW_W-1:0] & mask_w & ~ROW_W'(3);
    end
endmodule

// File: rtl/acc_row_stepper.sv
module acc_row_stepper (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       adv,
    input  logic [1:0] last_idx,
    output logic [1:0] sub,
    output logic [1:0] rix,
    output logic       final_step,
    output logic       reg_wrap
);
    assign reg_wrap   = (sub == 2'd3);
    assign final_step = reg_wrap && (rix == last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub <= 2'd0;
            rix <= 2'd0;
        end else if (clear) begin
            sub <= 2'd0;
            rix <= 2'd0;
        end else if (adv) begin
            sub <= sub + 2'd1;
            if (reg_wrap) rix <= rix + 2'd1;
        end
    end

    // R4
    sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clear && !reg_wrap) |=> (sub == $past(sub) + 2'd1));
endmodule

// File: rtl/acc_row_seq.sv
module acc_row_seq
    import acc_row_pkg::*;
#(
    parameter int VEC_BITS = 512,
    localparam int ROWS    = VEC_BITS / 8,
    localparam int ROW_W   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       base_sel_i,
    input  logic [31:0]      base_val_i,
    input  logic [1:0]       offs_i,
    input  logic [1:0]       grp_i,
    input  logic [4:0]       first_reg_i,
    input  logic             size_i,
    input  logic             wide_ok_i,
    output logic             valid_o,
    output logic [ROW_W-1:0] row_o,
    output logic [4:0]       src_reg_o,
    output logic [1:0]       sub_o,
    output logic [3:0]       base_reg_o,
    output logic             done_o,
    output logic             fault_o
);
    seq_state_t       state_q, state_d;
    logic [ROW_W:0]   stride_w, stride_q;
    logic [ROW_W-1:0] row0_w, cur_row_q;
    logic [4:0]       first_q;
    logic [1:0]       sel_q, last_q, sub_w, rix_w;
    logic             final_w, wrap_w, bad_req, accept;

    acc_row_origin #(.ROWS(ROWS), .ROW_W(ROW_W)) u_origin (
        .base_val (base_val_i),
        .offs     (offs_i),
        .grp      (grp_i),
        .stride   (stride_w),
        .row0     (row0_w)
    );

    acc_row_stepper u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .adv        (state_q == ST_RUN),
        .last_idx   (last_q),
        .sub        (sub_w),
        .rix        (rix_w),
        .final_step (final_w),
        .reg_wrap   (wrap_w)
    );

    assign bad_req = (size_i && !wide_ok_i) || (grp_i == GRP_RESERVED);
    assign accept  = (state_q == ST_IDLE) && start_i && !bad_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = bad_req ? ST_FAULT : ST_RUN;
            ST_RUN:   if (final_w) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            stride_q  <= '0;
            cur_row_q <= '0;
            first_q   <= '0;
            sel_q     <= '0;
            last_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                stride_q  <= stride_w;
                cur_row_q <= row0_w;
                first_q   <= first_reg_i;
                sel_q     <= base_sel_i;
                last_q    <= 2'((3'd1 << grp_i) - 3'd1);
            end else if (state_q == ST_RUN && wrap_w) begin
                cur_row_q <= cur_row_q + ROW_W'(stride_q);
            end
        end
    end

    always_comb begin
        valid_o    = (state_q == ST_RUN);
        done_o     = (state_q == ST_FIN);
        fault_o    = (state_q == ST_FAULT);
        sub_o      = sub_w;
        row_o      = cur_row_q + ROW_W'(sub_w);
        src_reg_o  = first_q + {3'd0, rix_w};
        base_reg_o = {2'b10, sel_q};
    end

    // R4
    row_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (row_o[1:0] == sub_o));
    // R5
    src_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && sub_o == 2'd3 && !final_w) |=> (src_reg_o == $past(src_reg_o) + 5'd1));
    // R6
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !valid_o && !done_o);
    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !valid_o && !fault_o);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && sub_o != 2'd3) |=> (valid_o && src_reg_o == $past(src_reg_o)
                                        && base_reg_o == $past(base_reg_o)));
endmodule

// File: tb/acc_row_seq_tb.sv
module acc_row_seq_tb;
    localparam int VEC_BITS = 512;
    localparam int ROWS     = VEC_BITS / 8;
    localparam int ROW_W    = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [1:0]       base_sel_i = '0;
    logic [31:0]      base_val_i = '0;
    logic [1:0]       offs_i = '0;
    logic [1:0]       grp_i = '0;
    logic [4:0]       first_reg_i = '0;
    logic             size_i = 1'b0;
    logic             wide_ok_i = 1'b1;
    logic             valid_o, done_o, fault_o;
    logic [ROW_W-1:0] row_o;
    logic [4:0]       src_reg_o;
    logic [1:0]       sub_o;
    logic [3:0]       base_reg_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    acc_row_seq #(.VEC_BITS(VEC_BITS)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_row(input logic [31:0] base, input int off, input int g,
                                   input int r, input int i);
        int stride;
        longint s;
        stride = ROWS >> g;
        s = longint'({32'd0, base + 32'(off * 4)}) % stride;
        s = s - (s % 4);
        return int'(s) + r * stride + i;
    endfunction

    task automatic poke_busy();
        start_i = 1'b1; base_sel_i = 2'd0; base_val_i = 32'd5;
        offs_i = 2'd2; grp_i = 2'd0; first_reg_i = 5'd9;
    endtask

    task automatic run_req(input int sel, input logic [31:0] base, input int off,
                           input int g, input int first, input bit poke);
        int n;
        @(negedge clk);
        start_i = 1'b1; base_sel_i = 2'(sel); base_val_i = base; offs_i = 2'(off);
        grp_i = 2'(g); first_reg_i = 5'(first); size_i = 1'b0; wide_ok_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 4 << g;
        for (int j = 0; j < n; j++) begin
            chk(valid_o == 1'b1, "R6 valid", valid_o, 1);
            chk(sub_o == 2'(j % 4), "R4 sub", sub_o, j % 4);
            chk(row_o == ROW_W'(exp_row(base, off, g, j / 4, j % 4)), "R3/R4/R5/R9 row",
                row_o, exp_row(base, off, g, j / 4, j % 4));
            chk(src_reg_o == 5'((first + j / 4) % 32), "R5 src", src_reg_o, (first + j / 4) % 32);
            chk(base_reg_o == 4'(8 + sel), "R2 base reg", base_reg_o, 8 + sel);
            // R7: a start during RUN must not disturb the sequence
            if (poke && j == 1) poke_busy(); else start_i = 1'b0;
            @(negedge clk);
        end
        chk(done_o == 1'b1 && valid_o == 1'b0, "R6 done", {done_o, valid_o}, 2);
        // R7: a start during FIN is ignored as well
        if (poke) poke_busy();
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0 && valid_o == 1'b0, "R6/R7 idle after done", {done_o, valid_o}, 0);
    endtask

    task automatic bad_req(input bit sz, input bit wok, input int g);
        @(negedge clk);
        start_i = 1'b1; size_i = sz; wide_ok_i = wok; grp_i = 2'(g);
        @(negedge clk);
        start_i = 1'b0; size_i = 1'b0; wide_ok_i = 1'b1;
        chk(fault_o == 1'b1 && valid_o == 1'b0, "R8 fault pulse", {fault_o, valid_o}, 2);
        @(negedge clk);
        chk(fault_o == 1'b0 && valid_o == 1'b0, "R8 no steps", {fault_o, valid_o}, 0);
    endtask

    initial begin
        repeat (3000000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (2) @(negedge clk);
        chk(valid_o == 0 && done_o == 0 && fault_o == 0, "R1 reset", {valid_o, done_o, fault_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 0 && done_o == 0 && fault_o == 0, "R1 idle", {valid_o, done_o, fault_o}, 0);
        run_req(0, 32'd0, 0, 0, 0, 0);
        run_req(3, 32'd77, 3, 2, 30, 0);
        run_req(1, 32'hFFFF_FFFE, 1, 1, 31, 0);
        run_req(2, 32'hFFFF_FFFF, 3, 2, 4, 0);
        run_req(1, 32'd13, 2, 1, 7, 1);
        run_req(2, 32'd63, 0, 0, 31, 1);
        bad_req(1'b1, 1'b0, 0);
        bad_req(1'b0, 1'b1, 3);
        run_req(0, 32'd20, 1, 1, 3, 0);
        for (int k = 0; k < 150; k++) begin
            run_req(int'($urandom % 4), $urandom, int'($urandom % 4),
                    int'($urandom % 3), int'($urandom % 32), ($urandom % 4) == 0);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule